// File: doc/BRIEF.md
# Processor Reset and Interrupt Control

This block sits beside the execution logic of a 16-bit processor core and decides three things: when an externally applied reset is genuine, when a hardware interrupt may break into the instruction stream, and when a wait-for-test instruction must freeze the core. The reset, maskable request, non-maskable request and test inputs are all asynchronous to the core clock. Each one passes through a synchronizer of configurable depth before any decision is made on it.

A reset pulse counts only once the synchronized pin has stayed high for a configurable number of consecutive clocks. While that qualified reset lasts, the block presents the start-up segment value (all ones) and pointer value (zero), and asks for the interrupt-enable flag to be cleared. Interrupts are granted only on an instruction-boundary strobe. A rising edge on the non-maskable input wins over the maskable level and always carries vector 2. A maskable request is granted only while the enable flag is set. A granted request stays presented until the execution side reports that it has taken it. A wait instruction stalls the core for as long as the synchronized test input is high.

Top module: `rictl_top`

## Requirements
- R1: A reset takes effect only after the synchronized reset pin has been high on HOLD_CLKS (default 4) consecutive clock edges. A shorter pulse leaves `arch_reset` low.
- R2: While reset is qualified, `arch_reset` and `if_clr` are 1, `cs_rst_val` is all ones and `ip_rst_val` is zero. Outside reset all four are 0. Reset ends SYNC_STAGES+1 edges after the pin falls.
- R3: During a qualified reset no acknowledge is raised. A non-maskable edge that is pending or being acknowledged is discarded.
- R4: A maskable request is granted only while the synchronized `intr_pin` is high and `if_flag` is 1. It stays level sensitive, so it is granted again at a later boundary if still held.
- R5: Each rising edge of the synchronized `nmi_pin` gives exactly one grant, whatever `if_flag` holds. That grant has `ack_nmi`=1 and `vec_num`=2. A pin held high after its grant produces no further grant.
- R6: When a non-maskable edge is pending and a maskable request is also valid at the same boundary, the non-maskable one is granted first.
- R7: `ack_req`, `ack_nmi` and `vec_num` hold steady until `ack_taken` is sampled high. Boundary strobes seen in the meantime start no new grant.
- R8: Grants happen only on a clock edge where `instr_bound` is 1. `ack_req` rises on that edge.
- R9: A wait strobe while the synchronized test input is 0 gives no stall.
- R10: A wait strobe while the synchronized test input is 1 raises `stall` in the same cycle. `stall` stays high until the synchronized test input is 0 and drops in that cycle.
- R11: A maskable grant presents `ack_nmi`=0 and `vec_num`=0. The vector number comes later from the acknowledge bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset of this block's flops |
| reset_pin | input | 1 | Asynchronous processor reset pin, active high |
| intr_pin | input | 1 | Asynchronous maskable interrupt request, level |
| nmi_pin | input | 1 | Asynchronous non-maskable request, edge |
| test_pin | input | 1 | Asynchronous test input polled by the wait instruction |
| wait_go | input | 1 | Wait instruction is executing this cycle |
| instr_bound | input | 1 | Instruction boundary strobe from execution |
| if_flag | input | 1 | Current interrupt-enable flag |
| ack_taken | input | 1 | Execution has taken the presented interrupt |
| arch_reset | output | 1 | Qualified reset in force |
| cs_rst_val | output | SEG_W | Code segment start value during reset |
| ip_rst_val | output | SEG_W | Instruction pointer start value during reset |
| if_clr | output | 1 | Clear the interrupt-enable flag |
| ack_req | output | 1 | Interrupt acknowledge requested |
| ack_nmi | output | 1 | Presented request is non-maskable |
| vec_num | output | VEC_W | Vector number for the presented request |
| stall | output | 1 | Hold the core for the wait instruction |

## Verification
The collision that matters is a non-maskable edge and a valid maskable level both present at one boundary strobe. The bench raises `intr_pin` with the flag set, pulses `nmi_pin`, waits until both have crossed the synchronizers, and only then strobes the boundary. It expects the non-maskable grant with vector 2 first. After acknowledging that grant and strobing again, it expects the maskable grant with vector 0. A second overlap pits a qualified reset against a pending non-maskable edge and a held maskable level. After reset the bench judges it by the absence of any grant at the following boundary.

// File: rtl/rictl_pkg.sv
// Package: shared constants for the reset and interrupt control unit.
// Assumes: vector width of at least 2 bits so the fixed vector fits.
package rictl_pkg;
    // Fixed vector number used by the non-maskable request.
    localparam int unsigned NMI_VEC = 2;
    // Vector presented for a maskable grant (real number comes from the bus cycle).
    localparam int unsigned MASK_VEC = 0;

    // Kind of request currently being acknowledged.
    typedef enum logic [1:0] {
        GR_NONE = 2'd0,
        GR_NMI  = 2'd1,
        GR_MASK = 2'd2
    } grant_e;
endpackage

// File: rtl/rictl_sync.sv
// Module: multi-bit, multi-stage synchronizer for asynchronous pins.
// Assumes: each bit is independent (no bus coherency required), STAGES >= 2.
module rictl_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rictl_reset_qual.sv
// Module: reset qualifier. Counts consecutive high samples of the synchronized
// reset pin and declares a processor reset once HOLD_CLKS are seen.
// Assumes: pin_s already synchronized; HOLD_CLKS >= 1.
module rictl_reset_qual #(
    parameter int unsigned HOLD_CLKS = 4,
    parameter int unsigned SEG_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_s,
    output logic             arch_reset,
    output logic [SEG_W-1:0] cs_rst_val,
    output logic [SEG_W-1:0] ip_rst_val,
    output logic             if_clr
);
    localparam int unsigned CW = $clog2(HOLD_CLKS + 1);
    localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_CLKS);

    logic [CW-1:0] hold_cnt;

    // Count consecutive high samples, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!pin_s) begin
            hold_cnt <= '0;
        end else if (hold_cnt != HOLD_MAX) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign arch_reset = (hold_cnt == HOLD_MAX);
    assign cs_rst_val = arch_reset ? {SEG_W{1'b1}} : '0;
    assign ip_rst_val = '0;
    assign if_clr     = arch_reset;

    // R1: reset can only start right after a high sample of the pin.
    p_rst_needs_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arch_reset) |-> $past(pin_s));

    // R2: a low pin sample ends the reset on the next edge.
    p_rst_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_s |=> !arch_reset);
endmodule

// File: rtl/rictl_irq_arb.sv
// Module: interrupt arbiter. Latches non-maskable edges, gates the maskable
// level with the enable flag, grants at instruction boundaries with
// non-maskable priority, and holds the grant until execution takes it.
// Assumes: nmi_s/intr_s are synchronized; arch_reset from the qualifier.
module rictl_irq_arb
    import rictl_pkg::*;
#(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arch_reset,
    input  logic             nmi_s,
    input  logic             intr_s,
    input  logic             if_flag,
    input  logic             instr_bound,
    input  logic             ack_taken,
    output logic             ack_req,
    output logic             ack_nmi,
    output logic [VEC_W-1:0] vec_num
);
    localparam logic [VEC_W-1:0] V_NMI  = VEC_W'(NMI_VEC);
    localparam logic [VEC_W-1:0] V_MASK = VEC_W'(MASK_VEC);

    logic   nmi_q;
    logic   nmi_pend;
    logic   nmi_rise;
    logic   slot_open;
    grant_e grant;
    grant_e held;

    assign nmi_rise  = nmi_s & ~nmi_q;
    assign slot_open = instr_bound & ~ack_req & ~arch_reset;

    // Pick the request to grant at this edge, non-maskable first.
    always_comb begin
        grant = GR_NONE;
        if (slot_open) begin
            if (nmi_pend)                grant = GR_NMI;
            else if (intr_s && if_flag)  grant = GR_MASK;
        end
    end

    // Remember the previous synchronized non-maskable level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= nmi_s;
    end

    // Keep one pending flag per edge; a fresh edge outranks the clear.
    always_ff @(posedge clk) begin
        if (!rst_n || arch_reset)   nmi_pend <= 1'b0;
        else if (nmi_rise)          nmi_pend <= 1'b1;
        else if (grant == GR_NMI)   nmi_pend <= 1'b0;
    end

    // Hold the granted request until execution confirms it.
    always_ff @(posedge clk) begin
        if (!rst_n || arch_reset)  held <= GR_NONE;
        else if (grant != GR_NONE) held <= grant;
        else if (ack_taken)        held <= GR_NONE;
    end

    assign ack_req = (held != GR_NONE);
    assign ack_nmi = (held == GR_NMI);
    assign vec_num = (held == GR_NMI) ? V_NMI : V_MASK;

    // R7: a presented grant persists until it is taken.
    p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_taken && !arch_reset) |=> (ack_req && $stable(vec_num)));

    // R8: a new grant only follows a boundary strobe.
    p_grant_at_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> $past(instr_bound));

    // R4: a new maskable grant needs the enable flag.
    p_mask_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_req) && !ack_nmi) |-> $past(if_flag));

    // R5: non-maskable grants carry the fixed vector.
    p_nmi_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_nmi) |-> (vec_num == V_NMI));

    // R3: reset clears any presented grant.
    p_reset_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arch_reset |=> !ack_req);
endmodule

// File: rtl/rictl_wait_stall.sv
// Module: wait-for-test stall. A wait strobe with test high stalls the core
// until the synchronized test level returns low.
// Assumes: test_s synchronized; wait_go is a one-cycle strobe held by the core
// only while it is issuing the wait instruction.
module rictl_wait_stall (
    input  logic clk,
    input  logic rst_n,
    input  logic arch_reset,
    input  logic test_s,
    input  logic wait_go,
    output logic stall
);
    logic waiting;

    assign stall = (wait_go | waiting) & test_s;

    // Remember an unfinished wait across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || arch_reset) waiting <= 1'b0;
        else                      waiting <= stall;
    end

    // R10: a stalled cycle with test still high keeps the wait alive.
    p_stall_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n || arch_reset)
        (stall && test_s) |=> waiting);

    // R9: a low test sample never stalls.
    p_low_test_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_s |-> !stall);
endmodule

// File: rtl/rictl_top.sv
// Module: reset and interrupt control unit top. Synchronizes the four
// asynchronous pins and wires the reset qualifier, interrupt arbiter and
// wait stall together.
// Assumes: one clock domain; rst_n is synchronous and active low.
module rictl_top #(
    parameter int unsigned HOLD_CLKS   = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SEG_W       = 16,
    parameter int unsigned VEC_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_pin,
    input  logic             intr_pin,
    input  logic             nmi_pin,
    input  logic             test_pin,
    input  logic             wait_go,
    input  logic             instr_bound,
    input  logic             if_flag,
    input  logic             ack_taken,
    output logic             arch_reset,
    output logic [SEG_W-1:0] cs_rst_val,
    output logic [SEG_W-1:0] ip_rst_val,
    output logic             if_clr,
    output logic             ack_req,
    output logic             ack_nmi,
    output logic [VEC_W-1:0] vec_num,
    output logic             stall
);
    localparam int unsigned NPINS = 4;

    logic [NPINS-1:0] pins_raw;
    logic [NPINS-1:0] pins_s;

    assign pins_raw = {test_pin, nmi_pin, intr_pin, reset_pin};

    rictl_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    rictl_reset_qual #(.HOLD_CLKS(HOLD_CLKS), .SEG_W(SEG_W)) u_rq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_s      (pins_s[0]),
        .arch_reset (arch_reset),
        .cs_rst_val (cs_rst_val),
        .ip_rst_val (ip_rst_val),
        .if_clr     (if_clr)
    );

    rictl_irq_arb #(.VEC_W(VEC_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .arch_reset  (arch_reset),
        .nmi_s       (pins_s[2]),
        .intr_s      (pins_s[1]),
        .if_flag     (if_flag),
        .instr_bound (instr_bound),
        .ack_taken   (ack_taken),
        .ack_req     (ack_req),
        .ack_nmi     (ack_nmi),
        .vec_num     (vec_num)
    );

    rictl_wait_stall u_ws (
        .clk        (clk),
        .rst_n      (rst_n),
        .arch_reset (arch_reset),
        .test_s     (pins_s[3]),
        .wait_go    (wait_go),
        .stall      (stall)
    );
endmodule

// File: tb/rictl_top_tb.sv
`timescale 1ns/1ps
module rictl_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_pin = 0, intr_pin = 0, nmi_pin = 0, test_pin = 0;
    logic wait_go = 0, instr_bound = 0, if_flag = 0, ack_taken = 0;
    logic arch_reset, if_clr, ack_req, ack_nmi, stall;
    logic [15:0] cs_rst_val, ip_rst_val;
    logic [7:0] vec_num;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rictl_top u_dut (
        .clk(clk), .rst_n(rst_n), .reset_pin(reset_pin), .intr_pin(intr_pin),
        .nmi_pin(nmi_pin), .test_pin(test_pin), .wait_go(wait_go),
        .instr_bound(instr_bound), .if_flag(if_flag), .ack_taken(ack_taken),
        .arch_reset(arch_reset), .cs_rst_val(cs_rst_val), .ip_rst_val(ip_rst_val),
        .if_clr(if_clr), .ack_req(ack_req), .ack_nmi(ack_nmi), .vec_num(vec_num),
        .stall(stall)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bound_pulse();
        @(negedge clk); instr_bound = 1;
        @(negedge clk); instr_bound = 0;
    endtask

    task automatic take_ack();
        @(negedge clk); ack_taken = 1;
        @(negedge clk); ack_taken = 0;
    endtask

    task automatic t_reset_state();
        chk(arch_reset == 0, "R2 idle arch_reset", arch_reset, 0);
        chk(cs_rst_val == 0, "R2 idle cs", cs_rst_val, 0);
        chk(ack_req == 0, "R8 idle ack", ack_req, 0);
        chk(stall == 0, "R9 idle stall", stall, 0);
    endtask

    task automatic t_reset_glitch();
        @(negedge clk); reset_pin = 1;
        edges(3); reset_pin = 0;
        edges(8);
        chk(arch_reset == 0, "R1 short pulse ignored", arch_reset, 0);
    endtask

    task automatic t_reset_hold();
        @(negedge clk); reset_pin = 1;
        edges(5);
        chk(arch_reset == 0, "R1 not yet qualified", arch_reset, 0);
        edges(1);
        chk(arch_reset == 1, "R1 qualified after hold", arch_reset, 1);
        chk(cs_rst_val == 16'hFFFF, "R2 cs all ones", cs_rst_val, 16'hFFFF);
        chk(ip_rst_val == 0, "R2 ip zero", ip_rst_val, 0);
        chk(if_clr == 1, "R2 if clear", if_clr, 1);
        reset_pin = 0;
        edges(2);
        chk(arch_reset == 1, "R2 still in reset", arch_reset, 1);
        edges(1);
        chk(arch_reset == 0, "R2 released", arch_reset, 0);
        chk(if_clr == 0, "R2 if_clr released", if_clr, 0);
    endtask

    task automatic t_intr_gate();
        if_flag = 0; intr_pin = 1;
        edges(4);
        bound_pulse();
        chk(ack_req == 0, "R4 masked by flag", ack_req, 0);
        if_flag = 1;
        edges(3);
        chk(ack_req == 0, "R8 no grant without boundary", ack_req, 0);
        bound_pulse();
        chk(ack_req == 1, "R4 granted with flag", ack_req, 1);
        chk(ack_nmi == 0, "R11 maskable kind", ack_nmi, 0);
        chk(vec_num == 0, "R11 maskable vector", vec_num, 0);
        take_ack();
        chk(ack_req == 0, "R7 released by taken", ack_req, 0);
        bound_pulse();
        chk(ack_req == 1, "R4 level regranted", ack_req, 1);
        take_ack();
        intr_pin = 0;
        edges(4);
        bound_pulse();
        chk(ack_req == 0, "R4 dropped request", ack_req, 0);
    endtask

    task automatic t_nmi();
        if_flag = 0;
        @(negedge clk); nmi_pin = 1;
        edges(4);
        chk(ack_req == 0, "R8 nmi waits for boundary", ack_req, 0);
        bound_pulse();
        chk(ack_req == 1, "R5 nmi ignores flag", ack_req, 1);
        chk(ack_nmi == 1, "R5 nmi kind", ack_nmi, 1);
        chk(vec_num == 2, "R5 nmi vector", vec_num, 2);
        bound_pulse();
        edges(2);
        chk(ack_req == 1 && vec_num == 2, "R7 held across boundary", ack_req, 1);
        take_ack();
        bound_pulse();
        chk(ack_req == 0, "R5 one edge one grant", ack_req, 0);
        nmi_pin = 0;
        edges(3);
    endtask

    task automatic t_priority();
        if_flag = 1; intr_pin = 1;
        @(negedge clk); nmi_pin = 1;
        edges(4); nmi_pin = 0;
        bound_pulse();
        chk(ack_nmi == 1, "R6 nmi first", ack_nmi, 1);
        chk(vec_num == 2, "R6 nmi vector first", vec_num, 2);
        take_ack();
        bound_pulse();
        chk(ack_req == 1 && ack_nmi == 0, "R6 maskable next", ack_nmi, 0);
        take_ack();
        intr_pin = 0;
        edges(4);
    endtask

    task automatic t_reset_kills();
        if_flag = 1; intr_pin = 1;
        @(negedge clk); nmi_pin = 1;
        edges(4); nmi_pin = 0;
        reset_pin = 1;
        edges(7);
        @(negedge clk); instr_bound = 1;
        @(negedge clk); instr_bound = 0;
        chk(ack_req == 0, "R3 no grant in reset", ack_req, 0);
        reset_pin = 0; intr_pin = 0;
        edges(5);
        bound_pulse();
        chk(ack_req == 0, "R3 pending nmi discarded", ack_req, 0);
    endtask

    task automatic t_wait();
        test_pin = 0;
        edges(3);
        @(negedge clk); wait_go = 1; #1;
        chk(stall == 0, "R9 wait with test low", stall, 0);
        @(negedge clk); wait_go = 0;
        test_pin = 1;
        edges(3);
        @(negedge clk); wait_go = 1; #1;
        chk(stall == 1, "R10 stall same cycle", stall, 1);
        @(negedge clk); wait_go = 0;
        edges(3);
        chk(stall == 1, "R10 stall held", stall, 1);
        test_pin = 0;
        edges(1);
        chk(stall == 1, "R10 stall until sync low", stall, 1);
        edges(1);
        chk(stall == 0, "R10 stall released", stall, 0);
    endtask

    initial begin
        edges(3);
        rst_n = 1;
        edges(2);
        t_reset_state();
        t_reset_glitch();
        t_reset_hold();
        t_intr_gate();
        t_nmi();
        t_priority();
        t_reset_kills();
        t_wait();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule